// File: doc/BRIEF.md
# Two-Bank Level Interrupt Aggregator

This block gathers 64 level-sensitive peripheral interrupt lines and 8 level-sensitive local interrupt lines. It reduces them to a normal interrupt request and a fast interrupt request. Software reaches it over a plain 32-bit register port with an address, a write strobe, write data and combinational read data. Enable masks are changed only through paired registers. In one register of the pair a 1 bit turns the enable on. In the other a 1 bit turns it off. Software therefore never has to read, modify and write a shared mask.

Software first reads a summary word. It holds the enabled local lines, one flag for each peripheral half that has enabled activity, and direct copies of eleven frequently used peripheral sources. It then reads the two peripheral pending words only when it needs more detail. The fast output carries one chosen source, peripheral or local, and skips the enable masks. A latency-critical handler can then be bound to that source on its own.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all enable masks, the fast enable and the fast select are zero, and both outputs are low. Input levels are not held in storage and need no reset.
- R2: Writes to the enable-set registers OR the written 1 bits into the mask and leave bits written as 0 unchanged. Offset 0x10 covers peripheral sources 0–31, offset 0x14 covers sources 32–63, and offset 0x18 covers local lines 0–7 from data bits 7:0. Reading any of them returns the current mask, zero-extended.
- R3: Writes to the enable-clear registers remove the written 1 bits from the mask. Offset 0x1C covers peripheral sources 0–31, offset 0x20 covers sources 32–63, and offset 0x24 covers the local lines. Reading them returns the bitwise inverse of the full 32-bit zero-extended mask, so bits 31:8 of 0x24 read as 1.
- R4: Offset 0x04 reads peripheral levels 0–31 ANDed with their enables. Offset 0x08 does the same for sources 32–63.
- R5: The summary word is read at offset 0x00. Bits 7:0 are the local levels ANDed with the local enables. Bit 8 is the OR of pending word 0x04 and bit 9 is the OR of pending word 0x08. Bits 20:10 are the enabled-pending states of peripheral sources 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, with source 7 in bit 10. Bits 31:21 read 0.
- R6: Offset 0x0C holds the fast control. Bit 7 is the fast enable and bits 6:0 are the source select. It reads back as written, with bits 31:8 at 0.
- R7: One clock after any change, the fast output equals the raw level of the selected source while bit 7 is set, and is 0 otherwise. Selects 0–63 pick peripheral lines, 64–71 pick local line select−64, and 72–127 keep the output low. The enable masks have no effect on this path.
- R8: One clock after any change, the normal output is high exactly when some source in either bank is both high and enabled.
- R9: Reads from any address outside the ten mapped word offsets return 0. This includes unaligned addresses. Writes to unmapped addresses or to offsets 0x00, 0x04 and 0x08 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_lvl_i | input | 64 | Peripheral interrupt levels |
| local_lvl_i | input | 8 | Local interrupt levels |
| reg_addr_i | input | 9 | Register byte address |
| reg_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
Each peripheral source is swept on its own. All levels are held high and only that one source is enabled. This shows that the pending words, the group flags and the duplicate slots pick the right line and no neighbour. The same sweep runs over the local lines. The fast path is swept over all 128 select values with a fixed asymmetric level pattern and all masks cleared. This separates the peripheral, local and dead select ranges, and shows that masks do not gate this path. Directed partial-bit set and clear writes, followed by stray writes to pending and unmapped offsets, separate set, clear and ignore behaviour on the mask registers.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_PERIPH   = 64;
  localparam int NUM_LOCAL    = 8;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 9;
  localparam int SEL_W        = 7;
  localparam int FAST_EN_BIT  = 7;
  localparam int PERIPH_WORDS = NUM_PERIPH / DATA_W;
  localparam int PIDX_W       = $clog2(NUM_PERIPH);
  localparam int LIDX_W       = $clog2(NUM_LOCAL);
  localparam int NUM_DUP      = 11;
  localparam int DUP_BASE     = NUM_LOCAL + PERIPH_WORDS;
  localparam int NUM_SOURCES  = NUM_PERIPH + NUM_LOCAL;

  // word offsets, fixed by the software view
  localparam int OFF_SUMMARY  = 'h00;
  localparam int OFF_PEND0    = 'h04;
  localparam int OFF_FASTCTL  = 'h0C;
  localparam int OFF_SET0     = 'h10;
  localparam int OFF_SETLOC   = 'h18;
  localparam int OFF_CLR0     = 'h1C;
  localparam int OFF_CLRLOC   = 'h24;

  // peripheral source mirrored into summary slot k
  function automatic int dup_src(input int k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      4: return 19;
      5: return 53;
      6: return 54;
      7: return 55;
      8: return 56;
      9: return 57;
      default: return 62;
    endcase
  endfunction

  // level of the source chosen by the fast select, masks not applied
  function automatic logic fast_pick(input logic [NUM_PERIPH-1:0] p,
                                     input logic [NUM_LOCAL-1:0]  l,
                                     input logic [SEL_W-1:0]      sel);
    logic [SEL_W-1:0] loc_idx;
    loc_idx = sel - SEL_W'(NUM_PERIPH);
    if (sel < SEL_W'(NUM_PERIPH))       return p[sel[PIDX_W-1:0]];
    else if (sel < SEL_W'(NUM_SOURCES)) return l[loc_idx[LIDX_W-1:0]];
    else                                return 1'b0;
  endfunction
endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (set_stb) mask <= mask | bits;
    else if (clr_stb) mask <= mask & ~bits;
  end

  assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask & $past(bits)) == $past(bits)));
  assert_set_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask & ~$past(bits)) == ($past(mask) & ~$past(bits))));
  assert_clr_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_stb) |=> ((mask & $past(bits)) == '0));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(mask));
endmodule

// File: rtl/irq_fast_route.sv
module irq_fast_route
  import irq_agg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] periph_lvl,
  input  logic [NUM_LOCAL-1:0]  local_lvl,
  input  logic                  fast_en,
  input  logic [SEL_W-1:0]      fast_sel,
  output logic                  fiq
);
  logic picked_w;
  assign picked_w = fast_pick(periph_lvl, local_lvl, fast_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fiq <= 1'b0;
    else        fiq <= fast_en & picked_w;
  end

  assert_fast_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |=> !fiq);
  assert_fast_dead_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_sel >= SEL_W'(NUM_SOURCES)) |=> !fiq);
  assert_fast_periph_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en && fast_sel < SEL_W'(NUM_PERIPH)) |=> (fiq == $past(periph_lvl[fast_sel[PIDX_W-1:0]])));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_agg_pkg::*;
(
  input  logic [NUM_PERIPH-1:0] pend_p,
  input  logic [NUM_LOCAL-1:0]  pend_l,
  output logic [DATA_W-1:0]     word
);
  logic [PERIPH_WORDS-1:0] grp_w;
  logic [NUM_DUP-1:0]      dup_w;

  for (genvar g = 0; g < PERIPH_WORDS; g++) begin : g_grp
    assign grp_w[g] = |pend_p[g*DATA_W +: DATA_W];
  end

  for (genvar k = 0; k < NUM_DUP; k++) begin : g_dup
    assign dup_w[k] = pend_p[dup_src(k)];
  end

  assign word = {{(DATA_W-DUP_BASE-NUM_DUP){1'b0}}, dup_w, grp_w, pend_l};

  always_comb begin
    assert_grp_matches_R5: assert (word[NUM_LOCAL] == (|pend_p[DATA_W-1:0]));
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] periph_lvl_i,
  input  logic [NUM_LOCAL-1:0]  local_lvl_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  irq_o,
  output logic                  fiq_o
);
  logic [NUM_PERIPH-1:0] pmask_w;
  logic [NUM_LOCAL-1:0]  lmask_w;
  logic [NUM_PERIPH-1:0] pend_p_w;
  logic [NUM_LOCAL-1:0]  pend_l_w;
  logic [DATA_W-1:0]     summary_w;
  logic                  any_pend_w;
  logic                  fast_en_q;
  logic [SEL_W-1:0]      fast_sel_q;
  logic                  fastctl_hit_w;
  logic                  set_loc_hit_w;
  logic                  clr_loc_hit_w;

  // peripheral enable words, one bank per 32 sources
  for (genvar w = 0; w < PERIPH_WORDS; w++) begin : g_pbank
    logic set_hit_w, clr_hit_w;
    assign set_hit_w = reg_we_i && (reg_addr_i == ADDR_W'(OFF_SET0 + 4*w));
    assign clr_hit_w = reg_we_i && (reg_addr_i == ADDR_W'(OFF_CLR0 + 4*w));
    irq_mask_bank #(.W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_hit_w),
      .clr_stb (clr_hit_w),
      .bits    (reg_wdata_i),
      .mask    (pmask_w[w*DATA_W +: DATA_W])
    );
  end

  assign set_loc_hit_w = reg_we_i && (reg_addr_i == ADDR_W'(OFF_SETLOC));
  assign clr_loc_hit_w = reg_we_i && (reg_addr_i == ADDR_W'(OFF_CLRLOC));

  irq_mask_bank #(.W(NUM_LOCAL)) u_lbank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (set_loc_hit_w),
    .clr_stb (clr_loc_hit_w),
    .bits    (reg_wdata_i[NUM_LOCAL-1:0]),
    .mask    (lmask_w)
  );

  // fast control register
  assign fastctl_hit_w = reg_we_i && (reg_addr_i == ADDR_W'(OFF_FASTCTL));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_en_q  <= 1'b0;
      fast_sel_q <= '0;
    end else if (fastctl_hit_w) begin
      fast_en_q  <= reg_wdata_i[FAST_EN_BIT];
      fast_sel_q <= reg_wdata_i[SEL_W-1:0];
    end
  end

  irq_fast_route u_fast (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_lvl (periph_lvl_i),
    .local_lvl  (local_lvl_i),
    .fast_en    (fast_en_q),
    .fast_sel   (fast_sel_q),
    .fiq        (fiq_o)
  );

  // pending and normal request
  assign pend_p_w   = periph_lvl_i & pmask_w;
  assign pend_l_w   = local_lvl_i & lmask_w;
  assign any_pend_w = (|pend_p_w) | (|pend_l_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= any_pend_w;
  end

  irq_summary u_sum (
    .pend_p (pend_p_w),
    .pend_l (pend_l_w),
    .word   (summary_w)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(OFF_SUMMARY)) reg_rdata_o = summary_w;
    if (reg_addr_i == ADDR_W'(OFF_FASTCTL)) begin
      reg_rdata_o[SEL_W-1:0]   = fast_sel_q;
      reg_rdata_o[FAST_EN_BIT] = fast_en_q;
    end
    if (reg_addr_i == ADDR_W'(OFF_SETLOC)) reg_rdata_o = DATA_W'(lmask_w);
    if (reg_addr_i == ADDR_W'(OFF_CLRLOC)) reg_rdata_o = ~DATA_W'(lmask_w);
    for (int w = 0; w < PERIPH_WORDS; w++) begin
      if (reg_addr_i == ADDR_W'(OFF_PEND0 + 4*w)) reg_rdata_o = pend_p_w[w*DATA_W +: DATA_W];
      if (reg_addr_i == ADDR_W'(OFF_SET0 + 4*w))  reg_rdata_o = pmask_w[w*DATA_W +: DATA_W];
      if (reg_addr_i == ADDR_W'(OFF_CLR0 + 4*w))  reg_rdata_o = ~pmask_w[w*DATA_W +: DATA_W];
    end
  end

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_lvl_i == '0 && local_lvl_i == '0) |=> !irq_o);
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pmask_w == '0 && lmask_w == '0) |=> !irq_o);
  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (summary_w[DUP_BASE-1:0] != '0) |=> irq_o);
  assert_fastctl_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fastctl_hit_w |=> (fast_sel_q == $past(reg_wdata_i[SEL_W-1:0])));
endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] periph_lvl_i = '0;
  logic [7:0]  local_lvl_i = '0;
  logic [8:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, fiq_o;
  int total = 0;
  int bad = 0;
  int dups [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

  always #10 clk = ~clk;

  irq_aggregator dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  function automatic logic [31:0] exp_summary(input logic [63:0] pp, input logic [7:0] pl);
    logic [31:0] s;
    s = {24'd0, pl};
    s[8] = pp[31:0] != 0;
    s[9] = pp[63:32] != 0;
    foreach (dups[k]) s[10 + k] = pp[dups[k]];
    return s;
  endfunction

  function automatic logic exp_fast(input logic [63:0] p, input logic [7:0] l, input int sel);
    if (sel < 64) return p[sel];
    if (sel < 72) return l[sel - 64];
    return 1'b0;
  endfunction

  initial begin
    #(20ns * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] pp;
    logic [63:0] fp;
    logic [7:0]  fl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(9'h10, r); chk("R1 set0", r, 32'h0);
    rd(9'h14, r); chk("R1 set1", r, 32'h0);
    rd(9'h18, r); chk("R1 setloc", r, 32'h0);
    rd(9'h0C, r); chk("R1 fastctl", r, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 fiq", {31'd0, fiq_o}, 0);
    periph_lvl_i = '1; local_lvl_i = '1;
    @(negedge clk); @(negedge clk);
    chk("R1 irq masked after reset", {31'd0, irq_o}, 0);
    rd(9'h00, r); chk("R1 summary masked", r, 32'h0);

    // R2 R3 partial set and clear
    wr(9'h10, 32'hF0F0_0000);
    wr(9'h10, 32'h0000_0F0F);
    rd(9'h10, r); chk("R2 set accumulates", r, 32'hF0F0_0F0F);
    rd(9'h1C, r); chk("R3 clear view inverted", r, 32'h0F0F_F0F0);
    wr(9'h1C, 32'h00F0_0F00);
    rd(9'h10, r); chk("R3 clear bits", r, 32'hF000_000F);
    wr(9'h18, 32'hFFFF_FF81);
    rd(9'h18, r); chk("R2 local set", r, 32'h0000_0081);
    rd(9'h24, r); chk("R3 local clear view", r, 32'hFFFF_FF7E);
    wr(9'h24, 32'h0000_0001);
    rd(9'h18, r); chk("R3 local clear", r, 32'h0000_0080);
    wr(9'h14, 32'h8000_0001);
    rd(9'h14, r); chk("R2 set high word", r, 32'h8000_0001);
    rd(9'h20, r); chk("R3 high clear view", r, 32'h7FFF_FFFE);

    // R9 stray writes
    wr(9'h0C, 32'h0000_0085);
    wr(9'h00, 32'hFFFF_FFFF);
    wr(9'h04, 32'hFFFF_FFFF);
    wr(9'h08, 32'hFFFF_FFFF);
    wr(9'h28, 32'hFFFF_FFFF);
    wr(9'h1FC, 32'hFFFF_FFFF);
    wr(9'h11, 32'hFFFF_FFFF);
    rd(9'h10, r); chk("R9 set0 untouched", r, 32'hF000_000F);
    rd(9'h14, r); chk("R9 set1 untouched", r, 32'h8000_0001);
    rd(9'h18, r); chk("R9 setloc untouched", r, 32'h0000_0080);
    rd(9'h0C, r); chk("R9 fastctl untouched", r, 32'h0000_0085);
    rd(9'h28, r); chk("R9 unmapped read", r, 32'h0);
    rd(9'h1FC, r); chk("R9 top read", r, 32'h0);
    rd(9'h11, r); chk("R9 unaligned read", r, 32'h0);

    // R4 R5 R8 single peripheral sweep
    wr(9'h0C, 32'h0);
    wr(9'h24, 32'hFFFF_FFFF);
    for (int i = 0; i < 64; i++) begin
      wr(9'h1C, 32'hFFFF_FFFF);
      wr(9'h20, 32'hFFFF_FFFF);
      if (i < 32) wr(9'h10, 32'h1 << i);
      else        wr(9'h14, 32'h1 << (i - 32));
      @(negedge clk);
      pp = 64'h1 << i;
      rd(9'h04, r); chk($sformatf("R4 pend low src%0d", i), r, pp[31:0]);
      rd(9'h08, r); chk($sformatf("R4 pend high src%0d", i), r, pp[63:32]);
      rd(9'h00, r); chk($sformatf("R5 summary src%0d", i), r, exp_summary(pp, 8'h0));
      chk($sformatf("R8 irq src%0d", i), {31'd0, irq_o}, 1);
    end
    periph_lvl_i = 64'hFFFF_FFFF_7FFF_FFFF;
    @(negedge clk); @(negedge clk);
    chk("R8 irq follows level drop", {31'd0, irq_o}, 1);
    periph_lvl_i = 64'h7FFF_FFFF_FFFF_FFFF;
    @(negedge clk); @(negedge clk);
    chk("R8 irq low when enabled line low", {31'd0, irq_o}, 0);
    rd(9'h00, r); chk("R5 summary idle", r, 32'h0);
    periph_lvl_i = '1;
    wr(9'h20, 32'hFFFF_FFFF);

    // local sweep
    for (int j = 0; j < 8; j++) begin
      wr(9'h24, 32'hFFFF_FFFF);
      wr(9'h18, 32'h1 << j);
      @(negedge clk);
      rd(9'h00, r); chk($sformatf("R5 summary local%0d", j), r, exp_summary(64'h0, 8'h1 << j));
      chk($sformatf("R8 irq local%0d", j), {31'd0, irq_o}, 1);
    end
    wr(9'h24, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R8 irq all masked", {31'd0, irq_o}, 0);

    // R6 R7 fast select sweep, masks all clear
    fp = 64'hA5C3_0F96_1E78_3C5A; fl = 8'h6B;
    periph_lvl_i = fp; local_lvl_i = fl;
    for (int s = 0; s < 128; s++) begin
      wr(9'h0C, 32'h80 | s);
      @(negedge clk);
      rd(9'h0C, r); chk($sformatf("R6 fastctl sel%0d", s), r, 32'h80 | s);
      chk($sformatf("R7 fiq sel%0d", s), {31'd0, fiq_o}, {31'd0, exp_fast(fp, fl, s)});
    end
    wr(9'h0C, 32'h0000_0041);
    @(negedge clk);
    chk("R7 fiq disabled", {31'd0, fiq_o}, 0);
    rd(9'h0C, r); chk("R6 fastctl disabled readback", r, 32'h41);
    wr(9'h0C, 32'h0000_00C1);
    @(negedge clk);
    chk("R7 fiq local1", {31'd0, fiq_o}, 1);
    local_lvl_i = 8'h69;
    @(negedge clk); @(negedge clk);
    chk("R7 fiq follows level", {31'd0, fiq_o}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule